// File: doc/BRIEF.md
# Grouped FIFO write formatter

This block sits between a source of 32-bit sample words and a pair of external FIFOs that feed a memory interface. One FIFO receives data words and the other receives chunk addresses. The memory interface stores 64-bit chunks, each built from two consecutive data words. It accepts writes only in runs of four cycles: every cycle writes one data word, and only the second and fourth cycles also write an address. A run that breaks this pattern corrupts the interface. The formatter therefore issues writes only in complete four-cycle groups. It pads a group with zero words when the source runs dry. Reset and reprogram requests, and trigger-based stops, are held back until the running group has finished.

Control comes from five level inputs: start, flush request, reprogram request, external trigger and software trigger. The block acts on the rising edge of each one. A start while idle clears the write counter and the chunk address and begins streaming. A flush or reprogram request produces a one-cycle flush pulse and then a one-cycle init pulse, after which the block is idle. A trigger ends a run and returns the block to idle.

Top module: `grp_fifo_writer`

## Requirements
- R1: Each control input acts only on its rising edge. Holding an input high has no further effect, so a start held high after a run ends does not begin a new run.
- R2: Data writes (`dat_we_o`) come only in unbroken groups of exactly four cycles, so the total number of data writes is always a multiple of four.
- R3: `adr_we_o` is high only on the second and fourth cycle of a group, and only while `dat_we_o` is high.
- R4: In a group cycle where `smp_valid_i` is low, the block still writes a data word with the value 0x00000000, and `smp_ready_o` stays low.
- R5: A flush or reprogram request that arrives during a group takes effect only after the fourth cycle of that group. The block then gives `flush_o` for one cycle, `init_o` for the next cycle, and is then idle.
- R6: A trigger (external or software) that arrives during a group lets that group complete, and the block returns to idle in the cycle after its fourth cycle.
- R7: At a group boundary, a new group starts only if `smp_valid_i` is high. Otherwise the block waits with `running_o` high and no writes. While waiting, valid data starts a group on the next cycle, a trigger sends the block to idle, and a flush or reprogram request sends it to the flush cycle.
- R8: A start edge while idle gives one non-running start cycle. If data is valid, the first write cycle begins two clock edges after the edge that first samples start high, and it writes no address.
- R9: `wr_cnt_o` is a 16-bit count that the start cycle clears to zero. It increases by one for every data-write cycle.
- R10: The first address after a start is 0. Each later address write presents the previous address plus 8.
- R11: `running_o` is high exactly in group cycles and waiting cycles. `smp_ready_o` is high only in group cycles where a real word is taken.
- R12: While `rst_ni` is low, every output is zero.
- R13: In a group cycle with `smp_valid_i` high, `dat_o` equals `smp_data_i` and `smp_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acts on its rising edge |
| flush_req_i | input | 1 | Flush request, acts on its rising edge |
| reprog_req_i | input | 1 | Reprogram request, acts on its rising edge |
| ext_trig_i | input | 1 | External stop trigger, acts on its rising edge |
| sw_trig_i | input | 1 | Software stop trigger, acts on its rising edge |
| smp_valid_i | input | 1 | A sample word is available |
| smp_data_i | input | 32 | Sample word |
| smp_ready_o | output | 1 | The sample word is taken this cycle |
| dat_we_o | output | 1 | Data FIFO write strobe |
| dat_o | output | 32 | Data FIFO word |
| adr_we_o | output | 1 | Address FIFO write strobe |
| adr_o | output | 32 | Address FIFO word (chunk address) |
| running_o | output | 1 | A run is active (writing or waiting for data) |
| flush_o | output | 1 | One-cycle flush pulse |
| init_o | output | 1 | One-cycle init pulse after a flush |
| wr_cnt_o | output | 16 | Count of data-write cycles since the last start |

## Verification
The bench targets requests that arrive in the first cycle of a group, because a design that acts on them at once would cut a group short. That would show up as a run of fewer than four writes or as a flush pulse directly after a write without an address. It drops `smp_valid_i` in the middle of a group, where a faulty design would stall, pass stale data or raise ready on a padding word. It holds start high across the return to idle, where level-sensitive logic would start a new run at once. Long random runs with overlapping triggers, requests and gaps in the data check the group phase, the address sequence and the count on every cycle, so a design whose address step or counter drifts fails quickly.

// File: rtl/grp_wr_pkg.sv
`timescale 1ns/1ps
package grp_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_INIT,
    ST_START,
    ST_GRP,
    ST_WAIT
  } grp_st_e;

  localparam int unsigned N_REQ     = 5;
  localparam int unsigned REQ_START = 0;
  localparam int unsigned REQ_FLUSH = 1;
  localparam int unsigned REQ_PROG  = 2;
  localparam int unsigned REQ_EXT   = 3;
  localparam int unsigned REQ_SW    = 4;

  localparam int unsigned GRP_LEN = 4;
  localparam int unsigned PH_W    = $clog2(GRP_LEN);
endpackage

// File: rtl/grp_edge_pulse.sv
`timescale 1ns/1ps
module grp_edge_pulse #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pls_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pls_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pls_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= lvl_i[g];
        pls_q[g]  <= lvl_i[g] & ~prev_q[g];
      end
    end
  end

  assign pls_o = pls_q;
endmodule

// File: rtl/grp_addr_gen.sv
`timescale 1ns/1ps
module grp_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (adv_i)  addr_q <= addr_q + STEP_V;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/grp_seq_fsm.sv
`timescale 1ns/1ps
module grp_seq_fsm
  import grp_wr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_p_i,
  input  logic             halt_p_i,
  input  logic             trig_p_i,
  input  logic             valid_i,
  output grp_st_e          state_o,
  output logic [PH_W-1:0]  phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_LEN - 1);

  grp_st_e          st_q;
  logic [PH_W-1:0]  ph_q;
  logic             pend_q;
  logic             term_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      pend_q <= 1'b0;
      term_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (halt_p_i) st_q <= ST_FLUSH;
          else if (start_p_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_FLUSH: st_q <= ST_INIT;
        ST_INIT:  st_q <= ST_IDLE;
        ST_START, ST_WAIT: begin
          if (halt_p_i) st_q <= ST_FLUSH;
          else if (st_q == ST_WAIT && trig_p_i) st_q <= ST_IDLE;
          else if (valid_i) begin
            st_q <= ST_GRP;
            ph_q <= '0;
          end else st_q <= ST_WAIT;
        end
        ST_GRP: begin
          cnt_q <= cnt_q + 1'b1;
          ph_q  <= ph_q + 1'b1;
          if (ph_q != PH_LAST) begin
            // requests are only recorded mid-group
            if (halt_p_i)      pend_q <= 1'b1;
            else if (trig_p_i) term_q <= 1'b1;
          end else begin
            pend_q <= 1'b0;
            term_q <= 1'b0;
            if (halt_p_i || pend_q)      st_q <= ST_FLUSH;
            else if (term_q || trig_p_i) st_q <= ST_IDLE;
            else if (!valid_i)           st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/grp_fifo_writer.sv
`timescale 1ns/1ps
module grp_fifo_writer
  import grp_wr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              flush_req_i,
  input  logic              reprog_req_i,
  input  logic              ext_trig_i,
  input  logic              sw_trig_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              smp_ready_o,
  output logic              dat_we_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              adr_we_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic              running_o,
  output logic              flush_o,
  output logic              init_o,
  output logic [CNT_W-1:0]  wr_cnt_o
);
  logic [N_REQ-1:0] lvl;
  logic [N_REQ-1:0] pls;
  grp_st_e          st;
  logic [PH_W-1:0]  ph;
  logic             in_grp;
  logic             adr_we;

  always_comb begin
    lvl            = '0;
    lvl[REQ_START] = start_i;
    lvl[REQ_FLUSH] = flush_req_i;
    lvl[REQ_PROG]  = reprog_req_i;
    lvl[REQ_EXT]   = ext_trig_i;
    lvl[REQ_SW]    = sw_trig_i;
  end

  grp_edge_pulse #(.N(N_REQ)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .pls_o  (pls)
  );

  grp_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_p_i (pls[REQ_START]),
    .halt_p_i  (pls[REQ_FLUSH] | pls[REQ_PROG]),
    .trig_p_i  (pls[REQ_EXT] | pls[REQ_SW]),
    .valid_i   (smp_valid_i),
    .state_o   (st),
    .phase_o   (ph),
    .cnt_o     (wr_cnt_o)
  );

  assign in_grp = (st == ST_GRP);
  assign adr_we = in_grp & ph[0];  // 2nd and 4th cycle of a group

  grp_addr_gen #(.ADDR_W(ADDR_W), .STEP(ADDR_STEP)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st == ST_START),
    .adv_i  (adr_we),
    .addr_o (adr_o)
  );

  assign dat_we_o    = in_grp;
  assign smp_ready_o = in_grp & smp_valid_i;
  assign dat_o       = (in_grp && smp_valid_i) ? smp_data_i : '0;
  assign adr_we_o    = adr_we;
  assign running_o   = in_grp | (st == ST_WAIT);
  assign flush_o     = (st == ST_FLUSH);
  assign init_o      = (st == ST_INIT);
endmodule

// File: rtl/grp_fifo_writer_chk.sv
`timescale 1ns/1ps
module grp_fifo_writer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              smp_ready_o,
  input logic              dat_we_o,
  input logic [DATA_W-1:0] dat_o,
  input logic              adr_we_o,
  input logic              running_o,
  input logic              flush_o,
  input logic [CNT_W-1:0]  wr_cnt_o
);
  p_grp_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dat_we_o) |-> $past(adr_we_o));

  p_adr_dat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_we_o |-> dat_we_o);

  p_adr_alt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_we_o |=> !adr_we_o);

  p_first_noadr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_we_o) |-> !adr_we_o);

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_we_o && !smp_valid_i) |-> (dat_o == '0 && !smp_ready_o));

  p_flush_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flush_o) && $past(dat_we_o)) |-> $past(adr_we_o));

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_o |=> (wr_cnt_o == $past(wr_cnt_o) + 1'b1));

  p_ready_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> dat_we_o);

  p_run_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_o |-> running_o);
endmodule

bind grp_fifo_writer grp_fifo_writer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_grp_fifo_writer.sv
`timescale 1ns/1ps
module tb_grp_fifo_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, flush_req_i = 0, reprog_req_i = 0;
  logic        ext_trig_i = 0, sw_trig_i = 0, smp_valid_i = 0;
  logic [31:0] smp_data_i = '0;
  logic        smp_ready_o, dat_we_o, adr_we_o, running_o, flush_o, init_o;
  logic [31:0] dat_o, adr_o;
  logic [15:0] wr_cnt_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  grp_fifo_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .flush_req_i(flush_req_i),
    .reprog_req_i(reprog_req_i), .ext_trig_i(ext_trig_i), .sw_trig_i(sw_trig_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .smp_ready_o(smp_ready_o),
    .dat_we_o(dat_we_o), .dat_o(dat_o), .adr_we_o(adr_we_o), .adr_o(adr_o),
    .running_o(running_o), .flush_o(flush_o), .init_o(init_o), .wr_cnt_o(wr_cnt_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // advance one edge, then drive new sample data
  task automatic step();
    @(posedge clk);
    #2;
    smp_data_i = $urandom;
  endtask

  function automatic logic [31:0] exp_adr(input int idx);
    return 32'(idx * 8);
  endfunction

  function automatic bit exp_adr_we(input int pos);
    return (pos == 1) || (pos == 3);
  endfunction

  // per-cycle monitor against the requirement rules
  int          m_pos = 0;
  int          m_aidx = 0;
  int          m_cnt = 0;
  bit          m_run = 0;
  always @(posedge clk) begin
    #8;
    if (rst_n) begin
      if (running_o && !m_run) begin
        m_aidx = 0;
        m_cnt  = 0;
      end
      if (running_o)
        chk(wr_cnt_o == 16'(m_cnt), "R9 count", 32'(wr_cnt_o), 32'(16'(m_cnt)));
      if (dat_we_o) begin
        chk(adr_we_o == exp_adr_we(m_pos), "R3 addr phase", 32'(adr_we_o),
            32'(exp_adr_we(m_pos)));
        if (adr_we_o) begin
          chk(adr_o == exp_adr(m_aidx), "R10 addr", adr_o, exp_adr(m_aidx));
          m_aidx++;
        end
        if (smp_valid_i)
          chk(dat_o == smp_data_i && smp_ready_o, "R13 pass", dat_o, smp_data_i);
        else
          chk(dat_o == 32'h0 && !smp_ready_o, "R4 pad", dat_o, 32'h0);
        chk(running_o, "R11 run in grp", 32'(running_o), 32'd1);
        m_pos = (m_pos + 1) % 4;
        m_cnt++;
      end else begin
        chk(m_pos == 0, "R2 group len", 32'(m_pos), 32'd0);
        chk(!adr_we_o && !smp_ready_o, "R11 idle strobes",
            {30'd0, adr_we_o, smp_ready_o}, 32'd0);
      end
      m_run = running_o;
    end
  end

  task automatic begin_run();
    start_i = 1;
    step();  // edge samples start high
    step();  // start cycle
    step();  // first group cycle if valid
    start_i = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(); step(); #1;
    chk({dat_we_o, adr_we_o, running_o, flush_o, init_o, smp_ready_o} == 6'd0 &&
        wr_cnt_o == 0 && dat_o == 0 && adr_o == 0, "R12 reset",
        {16'd0, wr_cnt_o}, 32'd0);
    rst_n = 1;
    step();

    // start with data, hold start high afterwards
    smp_valid_i = 1;
    start_i = 1;
    step(); step(); #1;
    chk(!running_o && !dat_we_o, "R8 start cycle", 32'(running_o), 32'd0);
    step(); #1;
    chk(dat_we_o && !adr_we_o, "R8 first write", {dat_we_o, adr_we_o}, 32'b10);
    chk(dat_o == smp_data_i, "R13 data", dat_o, smp_data_i);
    step(); #1;
    chk(adr_we_o && adr_o == 0, "R10 first addr", adr_o, 32'd0);
    step(); step(); #1;
    chk(adr_we_o && adr_o == 8, "R10 second addr", adr_o, 32'd8);
    chk(wr_cnt_o == 3, "R9 count mid", 32'(wr_cnt_o), 32'd3);
    step();             // ph0 of second group
    sw_trig_i = 1;
    step(); step(); step(); #1;
    chk(dat_we_o && adr_we_o, "R6 group finishes", {dat_we_o, adr_we_o}, 32'b11);
    step(); #1;
    chk(!running_o && !dat_we_o, "R6 idle after", 32'(running_o), 32'd0);
    for (int i = 0; i < 5; i++) begin
      step(); #1;
      chk(!running_o, "R1 held start no restart", 32'(running_o), 32'd0);
    end
    start_i = 0;
    sw_trig_i = 0;
    step();

    // flush request deferred
    begin_run();
    flush_req_i = 1;
    step(); step(); step(); #1;
    chk(dat_we_o && !flush_o, "R5 no flush mid", {dat_we_o, flush_o}, 32'b10);
    step(); #1;
    chk(flush_o && !dat_we_o, "R5 flush", {flush_o, dat_we_o}, 32'b10);
    step(); #1;
    chk(init_o && !flush_o, "R5 init", {init_o, flush_o}, 32'b10);
    step(); #1;
    chk(!init_o && !running_o && !flush_o, "R5 idle", 32'(init_o), 32'd0);
    flush_req_i = 0;
    step();

    // data dries mid-group, waits, resumes, trigger in wait
    begin_run();
    smp_valid_i = 0;
    step(); #1;
    chk(dat_we_o && dat_o == 0 && !smp_ready_o, "R4 dummy", dat_o, 32'd0);
    step(); step(); step(); #1;
    chk(running_o && !dat_we_o, "R7 wait", {running_o, dat_we_o}, 32'b10);
    step(); #1;
    chk(running_o && !dat_we_o, "R7 still wait", {running_o, dat_we_o}, 32'b10);
    smp_valid_i = 1;
    step(); #1;
    chk(dat_we_o && !adr_we_o, "R7 resume", {dat_we_o, adr_we_o}, 32'b10);
    smp_valid_i = 0;
    step(); step(); step(); step(); #1;
    chk(running_o && !dat_we_o, "R7 wait again", {running_o, dat_we_o}, 32'b10);
    ext_trig_i = 1;
    step(); step(); #1;
    chk(!running_o, "R7 trig to idle", 32'(running_o), 32'd0);
    ext_trig_i = 0;
    step();

    // reprogram while waiting
    begin_run(); #1;
    chk(running_o && !dat_we_o, "R7 wait from start", {running_o, dat_we_o}, 32'b10);
    reprog_req_i = 1;
    step(); step(); #1;
    chk(flush_o, "R7 reprog in wait", 32'(flush_o), 32'd1);
    step(); #1;
    chk(init_o, "R5 init after reprog", 32'(init_o), 32'd1);
    reprog_req_i = 0;
    step(); step();

    // constrained random, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      smp_valid_i  = ($urandom % 4) != 0;
      start_i      = ($urandom % 12) == 0;
      sw_trig_i    = ($urandom % 60) == 0;
      ext_trig_i   = ($urandom % 70) == 0;
      flush_req_i  = ($urandom % 97) == 0;
      reprog_req_i = ($urandom % 113) == 0;
      step();
    end
    {start_i, sw_trig_i, ext_trig_i, flush_req_i, reprog_req_i} = '0;
    repeat (10) step();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule